// File: doc/BRIEF.md
# Receive Stop and Flush Controller

This block sits between an Ethernet receive byte stream and a small receive buffer. It decides which incoming bytes are stored. It takes the receiver from running to halted when the host drops the enable bit, and it announces the halt with a single-cycle pulse. Once the receiver is halted, it honours a host request to empty the buffer. For every frame that ends, it produces a status word whose error bit merges the MAC's checksum verdict with the PHY receive-error marker.

The stream carries a byte strobe, frame start and end markers, and a per-byte PHY error flag. Two more inputs are sampled together with the end marker: a checksum-mismatch flag and a late-collision flag. The host side has three parts: a level enable, a one-cycle pulse that sets the flush request bit, and a readable copy of that bit, which drops by itself once the flush is done. A consumer drains the buffer through a read strobe, with the head byte always presented on the read data port. After reset the receiver is halted until the enable is seen high.

Top module: `rx_halt_flush_ctrl`

## Requirements
- R1: After reset, `rx_halted_o`=1, `stop_pulse_o`=0, `flush_busy_o`=0, `fifo_empty_o`=1 and `stat_valid_o`=0.
- R2: If `rx_en_i` is low while no frame is in progress, `rx_halted_o` rises one cycle later and `stop_pulse_o` is high for exactly that first halted cycle.
- R3: A frame already accepted when `rx_en_i` falls is stored to its end marker. The halt (with its pulse) is declared in the cycle after the end byte, together with that frame's status.
- R4: A start marker is not accepted while halted, nor in a cycle where `rx_en_i` is low. Such a frame writes no byte and produces no status.
- R5: While halted with no flush pending, `rx_en_i` high returns the receiver to running one cycle later, and the next frame is stored.
- R6: While halted, a set flush request empties the buffer. `flush_busy_o` reads 1 for one cycle, and in the cycle it reads 0 again `fifo_empty_o` is already 1.
- R7: A flush request made while the receiver is running or draining is held, with `flush_busy_o` high and buffer contents untouched, until the halt. It is then carried out in the first halted cycle.
- R8: `stat_valid_o` pulses one cycle after each accepted end byte. `stat_word_o` holds: bit 0 checksum error, bit 1 short frame, bit 2 oversize (length above MAX_LEN), bit 3 late collision, and bits [LEN_W+3:4] the byte count saturated at MAX_LEN+1.
- R9: For a frame of length MIN_LEN..MAX_LEN without late collision, bit 0 is 1 when the checksum-mismatch flag is set at the end byte, or when `in_rxer_i` was high on any accepted byte of the frame, even with a good checksum.
- R10: Bit 0 is 0 for frames shorter than MIN_LEN (bit 1 set), frames longer than MAX_LEN (bit 2 set) and late-collision frames, whatever the error inputs are.
- R11: Stored bytes are read in arrival order, with `rd_data_o` showing the head byte. Bytes that arrive while the buffer holds DEPTH bytes are dropped, and a read while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Host receiver enable level |
| flush_set_i | input | 1 | One-cycle pulse that sets the flush request bit |
| flush_busy_o | output | 1 | Flush request bit; clears itself when the flush is done |
| in_valid_i | input | 1 | Byte strobe of the receive stream |
| in_sop_i | input | 1 | First byte of a frame |
| in_eop_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Received byte |
| in_rxer_i | input | 1 | PHY receive error flag for this byte |
| in_crc_bad_i | input | 1 | Checksum mismatch, sampled with the end byte |
| in_late_col_i | input | 1 | Late collision, sampled with the end byte |
| rd_en_i | input | 1 | Pop the head byte |
| rd_data_o | output | 8 | Head byte of the buffer |
| fifo_empty_o | output | 1 | Buffer holds no byte |
| rx_halted_o | output | 1 | Receiver is halted |
| stop_pulse_o | output | 1 | One-cycle pulse on entering the halted state |
| stat_valid_o | output | 1 | Status word valid strobe |
| stat_word_o | output | LEN_W+4 | Per-frame status word |

## Verification
The bench builds the block with DEPTH=8, MIN_LEN=4 and MAX_LEN=10. With these values the short-frame, in-range and oversize boundaries, as well as length saturation at 11, all fall within frames of one to thirteen bytes. The bench sweeps every one of those lengths against all eight combinations of checksum error, PHY error and late collision, and computes each status word arithmetically. The small buffer lets a ten-byte frame show overflow dropping directly. The halt, pending-flush and resume orderings are each driven once with cycle-exact checks.

// File: rtl/rxhf_pkg.sv
package rxhf_pkg;
    typedef enum logic [1:0] {
        RX_RUN   = 2'd0,
        RX_DRAIN = 2'd1,
        RX_HALT  = 2'd2
    } rx_state_e;

    localparam int STAT_CRC     = 0;
    localparam int STAT_RUNT    = 1;
    localparam int STAT_LONG    = 2;
    localparam int STAT_LCOL    = 3;
    localparam int STAT_LEN_LSB = 4;
endpackage

// File: rtl/rxhf_ctrl.sv
module rxhf_ctrl
    import rxhf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en_i,
    input  logic flush_set_i,
    input  logic in_valid_i,
    input  logic in_sop_i,
    input  logic in_eop_i,
    output logic accept_o,
    output logic start_o,
    output logic end_o,
    output logic fifo_clr_o,
    output logic halted_o,
    output logic stop_pulse_o,
    output logic flush_busy_o
);
    typedef struct packed {
        rx_state_e state;
        logic      in_frame;
        logic      flush;
        logic      stop;
    } ctrl_t;

    ctrl_t c_q, c_d;
    logic  acc, st, fin, clr;

    always_comb begin
        c_d = c_q;
        acc = c_q.in_frame ? in_valid_i
                           : (in_valid_i & in_sop_i & rx_en_i & (c_q.state == RX_RUN));
        st  = acc & ~c_q.in_frame;
        fin = acc & in_eop_i;
        clr = (c_q.state == RX_HALT) & c_q.flush;

        c_d.in_frame = (c_q.in_frame | st) & ~fin;
        c_d.flush    = (c_q.flush & ~clr) | flush_set_i;

        case (c_q.state)
            RX_RUN:   if (!rx_en_i) c_d.state = c_d.in_frame ? RX_DRAIN : RX_HALT;
            RX_DRAIN: if (fin) c_d.state = RX_HALT;
            RX_HALT:  if (rx_en_i && !c_q.flush) c_d.state = RX_RUN;
            default:  c_d.state = RX_HALT;
        endcase

        c_d.stop = (c_d.state == RX_HALT) && (c_q.state != RX_HALT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state    <= RX_HALT;
            c_q.in_frame <= 1'b0;
            c_q.flush    <= 1'b0;
            c_q.stop     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign accept_o     = acc;
    assign start_o      = st;
    assign end_o        = fin;
    assign fifo_clr_o   = clr;
    assign halted_o     = (c_q.state == RX_HALT);
    assign stop_pulse_o = c_q.stop;
    assign flush_busy_o = c_q.flush;

    // R2
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.stop |=> !c_q.stop);

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == RX_DRAIN) && !(in_valid_i && in_eop_i) |=> (c_q.state == RX_DRAIN));
endmodule

// File: rtl/rxhf_status.sv
module rxhf_status
    import rxhf_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int LEN_W   = 11,
    parameter int STAT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              start_i,
    input  logic              end_i,
    input  logic              rxer_i,
    input  logic              crc_bad_i,
    input  logic              late_col_i,
    output logic              stat_valid_o,
    output logic [STAT_W-1:0] stat_word_o
);
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              rxer;
        logic              valid;
        logic [STAT_W-1:0] word;
    } stat_t;

    stat_t            s_q, s_d;
    logic [LEN_W-1:0] len_now;
    logic             rxer_now, runt, long_f;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        len_now   = s_q.len;
        rxer_now  = s_q.rxer;
        runt      = 1'b0;
        long_f    = 1'b0;
        if (accept_i) begin
            if (start_i)               len_now = LEN_W'(1);
            else if (s_q.len == LEN_SAT) len_now = LEN_SAT;
            else                       len_now = s_q.len + LEN_W'(1);
            rxer_now = (start_i ? 1'b0 : s_q.rxer) | rxer_i;
            s_d.len  = len_now;
            s_d.rxer = rxer_now;
            if (end_i) begin
                runt   = int'(len_now) < MIN_LEN;
                long_f = int'(len_now) > MAX_LEN;
                s_d.word = '0;
                s_d.word[STAT_CRC]  = (crc_bad_i | rxer_now) & ~runt & ~long_f & ~late_col_i;
                s_d.word[STAT_RUNT] = runt;
                s_d.word[STAT_LONG] = long_f;
                s_d.word[STAT_LCOL] = late_col_i;
                s_d.word[STAT_LEN_LSB +: LEN_W] = len_now;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_valid_o = s_q.valid;
    assign stat_word_o  = s_q.word;

    // R10
    crc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> !(s_q.word[STAT_CRC] &&
                        (s_q.word[STAT_RUNT] || s_q.word[STAT_LONG] || s_q.word[STAT_LCOL])));
endmodule

// File: rtl/rxhf_fifo.sv
module rxhf_fifo #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    output logic       empty_o
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t          p_q, p_d;
    logic [PW-1:0] fill;
    logic          we, re, full;
    logic [7:0]    mem [DEPTH];

    always_comb begin
        fill = p_q.wr - p_q.rd;
        full = (fill == PW'(DEPTH));
        we   = wr_en_i & ~full;
        re   = rd_en_i & (fill != '0);
        p_d  = p_q;
        p_d.wr = p_q.wr + PW'(we);
        p_d.rd = p_q.rd + PW'(re);
        if (clr_i) p_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && p_q.wr[AW-1:0] == AW'(g)) mem[g] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[p_q.rd[AW-1:0]];
    assign empty_o   = (fill == '0);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));
endmodule

// File: rtl/rx_halt_flush_ctrl.sv
module rx_halt_flush_ctrl #(
    parameter  int DEPTH   = 32,
    parameter  int MIN_LEN = 64,
    parameter  int MAX_LEN = 1518,
    localparam int LEN_W   = $clog2(MAX_LEN + 2),
    localparam int STAT_W  = LEN_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_i,
    input  logic              flush_set_i,
    output logic              flush_busy_o,
    input  logic              in_valid_i,
    input  logic              in_sop_i,
    input  logic              in_eop_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_rxer_i,
    input  logic              in_crc_bad_i,
    input  logic              in_late_col_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    output logic              fifo_empty_o,
    output logic              rx_halted_o,
    output logic              stop_pulse_o,
    output logic              stat_valid_o,
    output logic [STAT_W-1:0] stat_word_o
);
    logic accept, start, fin, clr;

    rxhf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_en_i      (rx_en_i),
        .flush_set_i  (flush_set_i),
        .in_valid_i   (in_valid_i),
        .in_sop_i     (in_sop_i),
        .in_eop_i     (in_eop_i),
        .accept_o     (accept),
        .start_o      (start),
        .end_o        (fin),
        .fifo_clr_o   (clr),
        .halted_o     (rx_halted_o),
        .stop_pulse_o (stop_pulse_o),
        .flush_busy_o (flush_busy_o)
    );

    rxhf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .wr_en_i   (accept),
        .wr_data_i (in_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .empty_o   (fifo_empty_o)
    );

    rxhf_status #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .STAT_W  (STAT_W)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .start_i      (start),
        .end_i        (fin),
        .rxer_i       (in_rxer_i),
        .crc_bad_i    (in_crc_bad_i),
        .late_col_i   (in_late_col_i),
        .stat_valid_o (stat_valid_o),
        .stat_word_o  (stat_word_o)
    );

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy_o) |-> fifo_empty_o);

    // R7
    flush_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy_o) |-> $past(rx_halted_o));

    // R4
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halted_o && $past(rx_halted_o) |-> !stat_valid_o);
endmodule

// File: tb/tb_rx_halt_flush_ctrl.sv
module tb_rx_halt_flush_ctrl;
    localparam int DEPTH   = 8;
    localparam int MIN_LEN = 4;
    localparam int MAX_LEN = 10;
    localparam int SW      = $clog2(MAX_LEN + 2) + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, flush_set = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_rxer = 1'b0, in_bad = 1'b0, in_lc = 1'b0, rd_en = 1'b0;
    logic flush_busy, fifo_empty, halted, stop_p, stat_valid;
    logic [7:0] rd_data;
    logic [SW-1:0] stat_word;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_halt_flush_ctrl #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .flush_set_i(flush_set),
        .flush_busy_o(flush_busy), .in_valid_i(in_valid), .in_sop_i(in_sop),
        .in_eop_i(in_eop), .in_data_i(in_data), .in_rxer_i(in_rxer),
        .in_crc_bad_i(in_bad), .in_late_col_i(in_lc), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .fifo_empty_o(fifo_empty), .rx_halted_o(halted),
        .stop_pulse_o(stop_p), .stat_valid_o(stat_valid), .stat_word_o(stat_word)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic s, input logic e,
                       input logic er, input logic b, input logic lc);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        in_rxer = er; in_bad = b; in_lc = lc;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_rxer = 1'b0; in_bad = 1'b0; in_lc = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic [7:0] base, input int er_at,
                              input logic b, input logic lc);
        for (int i = 0; i < len; i++)
            put(base + 8'(i), i == 0, i == len - 1, i == er_at,
                (i == len - 1) & b, (i == len - 1) & lc);
        idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 halted", halted, 1);
        check("R1 stop", stop_p, 0);
        check("R1 busy", flush_busy, 0);
        check("R1 empty", fifo_empty, 1);
        check("R1 stat_valid", stat_valid, 0);

        // R5 enable from reset
        rx_en = 1'b1;
        @(negedge clk);
        check("R5 running", halted, 0);
        check("R5 no pulse", stop_p, 0);

        // R11 order
        send_frame(5, 8'hA0, -1, 1'b0, 1'b0);
        check("R11 not empty", fifo_empty, 0);
        for (int i = 0; i < 5; i++) begin
            check("R11 order", rd_data, 8'hA0 + i);
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        check("R11 drained", fifo_empty, 1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 read while empty", fifo_empty, 1);

        // R11 overflow drop
        send_frame(10, 8'h40, -1, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            check("R11 overflow keep", rd_data, 8'h40 + i);
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        check("R11 overflow dropped", fifo_empty, 1);

        // R8 R9 R10 sweep
        rd_en = 1'b1;
        for (int len = 1; len <= 13; len++) begin
            for (int c = 0; c < 8; c++) begin
                logic b, er, lc, runt, lng, crc;
                int lenf, exp;
                b = c[0]; er = c[1]; lc = c[2];
                send_frame(len, 8'(len * 16), er ? len / 2 : -1, b, lc);
                runt = len < MIN_LEN;
                lng  = len > MAX_LEN;
                crc  = (b | er) & ~runt & ~lng & ~lc;
                lenf = (len > MAX_LEN + 1) ? MAX_LEN + 1 : len;
                exp  = (lenf << 4) | (int'(lc) << 3) | (int'(lng) << 2) | (int'(runt) << 1) | int'(crc);
                check("R8 stat valid", stat_valid, 1);
                if (runt | lng | lc) check("R10 status word", stat_word, exp);
                else                 check("R9 status word", stat_word, exp);
            end
        end
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check("R8 valid is a pulse", stat_valid, 0);
        check("R11 swept buffer empty", fifo_empty, 1);

        // R2 idle halt
        rx_en = 1'b0;
        @(negedge clk);
        check("R2 halted", halted, 1);
        check("R2 pulse", stop_p, 1);
        @(negedge clk);
        check("R2 pulse ends", stop_p, 0);
        check("R2 still halted", halted, 1);

        // R4 start ignored while halted
        send_frame(3, 8'h11, -1, 1'b0, 1'b0);
        check("R4 no status", stat_valid, 0);
        check("R4 nothing stored", fifo_empty, 1);

        // R5 resume then R6 flush while halted
        rx_en = 1'b1;
        @(negedge clk);
        check("R5 resumed", halted, 0);
        send_frame(3, 8'h21, -1, 1'b0, 1'b0);
        check("R5 stored", fifo_empty, 0);
        check("R5 head", rd_data, 8'h21);
        rx_en = 1'b0;
        @(negedge clk);
        check("R2 halted again", halted, 1);
        flush_set = 1'b1;
        @(negedge clk);
        flush_set = 1'b0;
        check("R6 busy", flush_busy, 1);
        check("R6 data kept until flush", fifo_empty, 0);
        @(negedge clk);
        check("R6 busy cleared", flush_busy, 0);
        check("R6 empty", fifo_empty, 1);

        // R3 frame in progress completes
        rx_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 3) check("R3 not halted mid-frame", halted, 0);
            in_valid = 1'b1; in_data = 8'h60 + 8'(i);
            in_sop = (i == 0); in_eop = (i == 5);
            in_rxer = 1'b0; in_bad = 1'b0; in_lc = 1'b0;
            if (i == 2) rx_en = 1'b0;
        end
        idle();
        check("R3 halted at end", halted, 1);
        check("R3 pulse at end", stop_p, 1);
        check("R3 status", stat_word, (6 << 4));
        check("R3 head kept", rd_data, 8'h60);

        // R7 flush pending while running
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        flush_set = 1'b1;
        @(negedge clk);
        flush_set = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R7 pending busy", flush_busy, 1);
            check("R7 data untouched", fifo_empty, 0);
            @(negedge clk);
        end
        rx_en = 1'b0;
        @(negedge clk);
        check("R7 halted", halted, 1);
        check("R7 still busy", flush_busy, 1);
        check("R7 not yet flushed", fifo_empty, 0);
        @(negedge clk);
        check("R7 done", flush_busy, 0);
        check("R7 empty", fifo_empty, 1);

        // R5 resume after flush, pointers restart
        rx_en = 1'b1;
        @(negedge clk);
        send_frame(5, 8'h80, -1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            check("R5 after flush order", rd_data, 8'h80 + i);
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        check("R5 drained", fifo_empty, 1);

        // R4 start in same cycle as disable
        @(negedge clk);
        rx_en = 1'b0;
        in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h99;
        put(8'h9A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        put(8'h9B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        check("R4 halted", halted, 1);
        check("R4 no status on refused frame", stat_valid, 0);
        check("R4 refused frame not stored", fifo_empty, 1);

        summary();
    end
endmodule